// File: doc/BRIEF.md
# I2C Bus Condition Status Tracker

This block watches the two wires of an I2C bus with the system clock and recognises START and STOP conditions on them. From those events and a few strobes from the rest of the controller it keeps three status flags: bus busy, repeated start seen, and arbitration lost. It places them in the top three bits of a read-only 8-bit status byte. The lower five bits are produced elsewhere in the controller and pass straight through.

The SCL and SDA inputs go through a two-stage synchronizer. One more register stage holds the previous sample, so that edges can be seen. A START is an SDA fall while SCL is high in both the current and the previous sample. A STOP is an SDA rise under the same SCL condition.

The flag strobes come from other parts of the controller:
- the master-mode request from software;
- an arbitration-loss pulse from the transmitter;
- a write of zero to the interrupt flag;
- a pulse meaning this node was not addressed as a slave.

Each strobe acts on the clock edge where it is sampled. When a set event and a clear event for the same flag meet in one cycle, the flag ends up set.

Top module: `i2c_bus_cond_status`

## Requirements
- R1: The status byte is, from bit 7 to bit 0: busy, repeated start, arbitration lost, last received bit, transmitting, addressed as slave, general call, first byte.
- R2: While rst_n is low on a clock edge, busy, repeated start and arbitration lost become 0. The synchronizer and history registers take the idle level 1.
- R3: Busy becomes 1 after a START and 0 after a STOP. A START is SDA going 1 to 0 while SCL stays 1. A STOP is SDA going 0 to 1 while SCL stays 1. An SDA change that is applied before clock edge k shows in the flag after edge k+2.
- R4: Repeated start becomes 1 when a START is detected while busy is already 1.
- R5: Repeated start becomes 0 on any of these: the interrupt-flag write-zero strobe, the not-addressed strobe, a START detected while busy is 0, or a STOP.
- R6: Arbitration lost becomes 1 on the cycle after the arbitration-loss pulse.
- R7: Arbitration lost becomes 1 on the cycle after a master-mode request that comes while busy is 1 and own_master_i is 0.
- R8: Arbitration lost becomes 0 only after the interrupt-flag write-zero strobe. A STOP, a START or the not-addressed strobe leaves it unchanged.
- R9: When a set and a clear for the same flag fall in the same cycle, the flag becomes 1.
- R10: Bits 4 to 0 show their pass-through inputs in the same cycle, with no register on the way.
- R11: An SDA change while SCL is 0 changes neither busy nor repeated start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| master_req_i | input | 1 | Software requests master mode (one-cycle strobe) |
| own_master_i | input | 1 | This node currently drives the bus as master |
| arb_lost_i | input | 1 | Arbitration lost during master transmission (pulse) |
| int_wr0_i | input | 1 | Zero written to the interrupt flag (pulse) |
| no_slave_addr_i | input | 1 | Transfer in which this node was not addressed as slave (pulse) |
| last_bit_i | input | 1 | Last received bit, passed to bit 4 |
| xmit_i | input | 1 | Transmitting, passed to bit 3 |
| slave_sel_i | input | 1 | Addressed as slave, passed to bit 2 |
| gen_call_i | input | 1 | General call received, passed to bit 1 |
| first_byte_i | input | 1 | First byte of a transfer, passed to bit 0 |
| status_o | output | 8 | Status byte |

## Verification
The hardest case to reach is a set and a clear of the same flag in one cycle. Line events pass through three register stages before they act, while the strobes act at once. The stimulus therefore drives a repeated START and then fires the write-zero and not-addressed strobes at a range of offsets around it, so that one offset lands on the detection cycle. Arbitration-loss pulses and write-zero strobes are also driven together and one cycle apart. A master request is issued while busy, both with and without own mastership.

// File: rtl/i2c_stat_pkg.sv
// Shared bit positions and flag type for the I2C bus condition status tracker.
// Assumes an 8-bit status byte with the condition flags in the top three bits.
package i2c_stat_pkg;
    localparam int STAT_W     = 8;
    localparam int BIT_BUSY   = 7;
    localparam int BIT_RSTART = 6;
    localparam int BIT_ARBL   = 5;

    typedef struct packed {
        logic busy;
        logic rstart;
        logic arbl;
    } cond_flags_t;
endpackage

// File: rtl/i2c_line_sampler.sv
// Synchronizes SCL/SDA, keeps one previous sample and flags START/STOP.
// Assumes the lines idle high; all sample registers reset to 1.
// start_o/stop_o are combinational and valid for one cycle per event.
module i2c_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [1:0] stage_q [SYNC_STAGES];
    logic [1:0] hist_q;
    logic [1:0] now_s;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // capture the raw line levels
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= 2'b11;
                    else        stage_q[0] <= {scl_i, sda_i};
                end
            end else begin : g_next
                // shift through the synchronizer chain
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= 2'b11;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign now_s = stage_q[LAST];

    // hold the previous synchronized sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= 2'b11;
        else        hist_q <= now_s;
    end

    // START: SDA falls while SCL high in both samples; STOP: SDA rises likewise
    always_comb begin
        start_o = now_s[1] & hist_q[1] &  hist_q[0] & ~now_s[0];
        stop_o  = now_s[1] & hist_q[1] & ~hist_q[0] &  now_s[0];
    end

    // R3
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_o, stop_o}));
    // R11
    no_event_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !now_s[1] |-> !(start_o || stop_o));
endmodule

// File: rtl/i2c_cond_flags.sv
// Keeps busy, repeated-start and arbitration-lost flags from line events and
// controller strobes. Assumes strobes are one-cycle pulses; set beats clear.
module i2c_cond_flags
    import i2c_stat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        stop_i,
    input  logic        master_req_i,
    input  logic        own_master_i,
    input  logic        arb_lost_i,
    input  logic        int_wr0_i,
    input  logic        no_slave_addr_i,
    output cond_flags_t flags_o
);
    cond_flags_t fl_q;
    logic rs_set, rs_clr, al_set;

    // decode set and clear events for each flag
    always_comb begin
        rs_set = start_i & fl_q.busy;
        rs_clr = int_wr0_i | no_slave_addr_i | stop_i | (start_i & ~fl_q.busy);
        al_set = arb_lost_i | (master_req_i & fl_q.busy & ~own_master_i);
    end

    // update flags; a set always wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            if (start_i)     fl_q.busy <= 1'b1;
            else if (stop_i) fl_q.busy <= 1'b0;

            if (rs_set)      fl_q.rstart <= 1'b1;
            else if (rs_clr) fl_q.rstart <= 1'b0;

            if (al_set)         fl_q.arbl <= 1'b1;
            else if (int_wr0_i) fl_q.arbl <= 1'b0;
        end
    end

    assign flags_o = fl_q;

    // R3
    busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> flags_o.busy);
    // R3
    idle_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !flags_o.busy);
    // R4
    rstart_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && flags_o.busy) |=> flags_o.rstart);
    // R5
    rstart_stop_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !flags_o.rstart);
    // R6
    arbl_pulse_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost_i |=> flags_o.arbl);
    // R8
    arbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o.arbl && !int_wr0_i) |=> flags_o.arbl);
endmodule

// File: rtl/i2c_bus_cond_status.sv
// Top: I2C bus condition status tracker. Detects START/STOP from the lines,
// tracks busy / repeated start / arbitration lost, and builds the status byte
// with five pass-through bits from the rest of the controller.
module i2c_bus_cond_status
    import i2c_stat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              master_req_i,
    input  logic              own_master_i,
    input  logic              arb_lost_i,
    input  logic              int_wr0_i,
    input  logic              no_slave_addr_i,
    input  logic              last_bit_i,
    input  logic              xmit_i,
    input  logic              slave_sel_i,
    input  logic              gen_call_i,
    input  logic              first_byte_i,
    output logic [STAT_W-1:0] status_o
);
    logic        start_det, stop_det;
    cond_flags_t flags;

    i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .start_o (start_det),
        .stop_o  (stop_det)
    );

    i2c_cond_flags u_flags (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_det),
        .stop_i          (stop_det),
        .master_req_i    (master_req_i),
        .own_master_i    (own_master_i),
        .arb_lost_i      (arb_lost_i),
        .int_wr0_i       (int_wr0_i),
        .no_slave_addr_i (no_slave_addr_i),
        .flags_o         (flags)
    );

    // assemble the status byte, top bits from flags, low bits passed through
    always_comb begin
        status_o             = {3'b000, last_bit_i, xmit_i, slave_sel_i,
                                gen_call_i, first_byte_i};
        status_o[BIT_BUSY]   = flags.busy;
        status_o[BIT_RSTART] = flags.rstart;
        status_o[BIT_ARBL]   = flags.arbl;
    end

    // R2
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (status_o[7:5] == 3'b000));
endmodule

// File: tb/tb_i2c_bus_cond_status.sv
// Bench for the I2C bus condition status tracker: a behavioural model fed from
// queued line samples, compared with the status byte on every clock.
module tb_i2c_bus_cond_status;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1;
    logic mreq = 0, ownm = 0, arbl = 0, iw0 = 0, nsa = 0;
    logic lb = 0, tx = 0, ss = 0, gc = 0, fb = 0;
    logic [7:0] stat;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    i2c_bus_cond_status dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .master_req_i(mreq), .own_master_i(ownm), .arb_lost_i(arbl),
        .int_wr0_i(iw0), .no_slave_addr_i(nsa), .last_bit_i(lb),
        .xmit_i(tx), .slave_sel_i(ss), .gen_call_i(gc), .first_byte_i(fb),
        .status_o(stat)
    );

    // reference model state
    bit m_busy, m_rs, m_al;
    bit q_scl[$];
    bit q_sda[$];

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // model update on each edge from line samples three edges old
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_rs = 0; m_al = 0;
            q_scl = '{1, 1, 1};
            q_sda = '{1, 1, 1};
        end else begin
            bit st, sp, rset, rclr, aset;
            st = q_scl[0] && q_scl[1] && q_sda[0] && !q_sda[1];
            sp = q_scl[0] && q_scl[1] && !q_sda[0] && q_sda[1];
            rset = st && m_busy;
            rclr = iw0 || nsa || sp || (st && !m_busy);
            aset = arbl || (mreq && m_busy && !ownm);
            if (rset) m_rs = 1; else if (rclr) m_rs = 0;
            if (aset) m_al = 1; else if (iw0) m_al = 0;
            if (st) m_busy = 1; else if (sp) m_busy = 0;
            void'(q_scl.pop_front());
            void'(q_sda.pop_front());
            q_scl.push_back(scl);
            q_sda.push_back(sda);
        end
    end

    // compare every field half a cycle after each edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 busy bit7", stat[7], m_busy);
            chk("R4/R5/R9 rstart bit6", stat[6], m_rs);
            chk("R6/R7/R8/R9 arbl bit5", stat[5], m_al);
            chk("R1/R10 passthru", stat[4:0], {lb, tx, ss, gc, fb});
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_c();
        sda = 1; cyc(1); scl = 1; cyc(3); sda = 0; cyc(4); scl = 0; cyc(2);
    endtask

    task automatic stop_c();
        sda = 0; cyc(1); scl = 1; cyc(3); sda = 1; cyc(6);
    endtask

    task automatic bits(int n, int pat);
        for (int i = 0; i < n; i++) begin
            scl = 0; cyc(1); sda = pat[i % 8]; cyc(2); scl = 1; cyc(3); scl = 0; cyc(1);
        end
    endtask

    task automatic pulse_iw0();  iw0 = 1;  cyc(1); iw0 = 0;  endtask
    task automatic pulse_nsa();  nsa = 1;  cyc(1); nsa = 0;  endtask
    task automatic pulse_arb();  arbl = 1; cyc(1); arbl = 0; endtask
    task automatic pulse_mreq(); mreq = 1; cyc(1); mreq = 0; endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        // R2: reset state, inputs held high and pass-through zero
        chk("R2 reset status", stat, 0);
        rst_n = 1;
        cyc(4);
        chk("R2 after reset", stat, 0);

        // R11: SDA toggles while SCL low: no event
        scl = 0; cyc(2); bits(0, 0);
        for (int i = 0; i < 4; i++) begin sda = ~sda; cyc(3); end
        scl = 1; sda = 1; cyc(5);
        chk("R11 idle kept", stat[7:6], 0);

        // R3/R4/R5: START, data, repeated START, data, STOP
        start_c();
        chk("R3 busy after start", stat[7], 1);
        bits(8, 8'hA5);
        start_c();
        chk("R4 rstart set", stat[6], 1);
        bits(8, 8'h3C);
        pulse_nsa(); cyc(1);
        chk("R5 rstart clr by no-addr", stat[6], 0);
        start_c();
        pulse_iw0(); cyc(1);
        chk("R5 rstart clr by wr0", stat[6], 0);
        start_c();
        stop_c();
        chk("R3 busy cleared by stop", stat[7], 0);
        chk("R5 rstart cleared by stop", stat[6], 0);

        // R6/R8: arbitration loss then clears
        start_c();
        pulse_arb(); cyc(1);
        chk("R6 arbl set", stat[5], 1);
        pulse_nsa(); stop_c();
        chk("R8 arbl kept past stop/no-addr", stat[5], 1);
        pulse_iw0(); cyc(1);
        chk("R8 arbl cleared by wr0", stat[5], 0);

        // R7: master request while busy, other vs own master
        start_c();
        ownm = 1; pulse_mreq(); cyc(1);
        chk("R7 own master no arbl", stat[5], 0);
        ownm = 0; pulse_mreq(); cyc(1);
        chk("R7 request while busy", stat[5], 1);
        pulse_iw0(); stop_c();
        pulse_mreq(); cyc(1);
        chk("R7 request when idle", stat[5], 0);

        // R9: set and clear in one cycle
        arbl = 1; iw0 = 1; cyc(1); arbl = 0; iw0 = 0; cyc(1);
        chk("R9 arbl set wins", stat[5], 1);
        pulse_iw0();
        start_c();
        for (int off = 0; off < 6; off++) begin
            sda = 1; cyc(1); scl = 1; cyc(3); sda = 0;
            cyc(off); iw0 = 1; nsa = off[0]; cyc(1); iw0 = 0; nsa = 0;
            cyc(4); scl = 0; cyc(2);
        end
        stop_c();

        // R10: walk pass-through inputs
        for (int v = 0; v < 32; v++) begin
            {lb, tx, ss, gc, fb} = v[4:0]; cyc(1);
        end
        cyc(4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule